// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a vector of external interrupt pins and turns them into masked, per-channel interrupt outputs. Each channel is given a sense mode through its own configuration register: active-low level, active-high level, falling edge, rising edge, or both edges. Pins are brought into the clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the previous one. Every detection is held in a sticky detect-status bit until software clears it by writing a one.

A single processor register block gates the detect bits onto the outputs. It has an enable-set location and an enable-clear location, so software never performs a read-modify-write on a shared mask. A request-status location reports the detect bits that are also enabled, and each channel's output line carries exactly its request-status bit. A monitor location returns the synchronized pin levels.

Software reaches the block over a 32-bit register port using a request/response handshake. A request is taken on any cycle where `req_valid` is high. `req_ready` is held at 1, so the port never applies back-pressure. A read returns `rsp_valid` together with `rsp_data` exactly one cycle after the request. The response has no back-pressure, so the requester must accept it in that cycle.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every enable bit, every detect bit and every configuration register is 0, all outputs in `irq_o` are 0, and reads of the request, enable, detect, monitor and configuration locations return 0 while the pins are low.
- R2: The configuration register of channel n is at byte address 0x180 + 4*n. A write stores bits [5:0] of the data as the sense code, and a read returns that code with bits [31:6] at 0.
- R3: Sense code bit 0 (0x01) selects active-low level and bit 1 (0x02) selects active-high level. While the level is active, the detect bit is set again on every cycle, so a write-one-clear takes effect only once the pin has gone inactive. The bit then stays set until it is cleared.
- R4: Sense code bit 2 (0x04) detects falling edges, bit 3 (0x08) detects rising edges, and 0x0C detects both. A change on a pin, applied between clock edges, appears in the detect bit and on `irq_o` after the third rising clock edge that follows it.
- R5: Detect status is at 0x100, with bit n belonging to channel n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a new detection and a clear of the same bit fall in the same cycle, the detection wins and the bit stays set.
- R6: Writing 1 to bit n at 0x08 enables channel n, and writing 1 to bit n at 0x04 disables it. Zero bits leave the mask unchanged. Reading 0x04 returns the enable mask.
- R7: Reading 0x00 returns the detect status ANDed with the enable mask, and `irq_o` equals that same vector.
- R8: Reading 0x104 returns the synchronized level of every pin, with bit n belonging to pin n.
- R9: Reads of unmapped or write-only addresses (including 0x08 and 0x0C) return 0, and writes to unmapped addresses change no state. A channel whose sense code is 0 never detects.
- R10: `req_ready` is always 1, and every read request produces `rsp_valid` with its data on the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| pin_i | input | NUM_CH (32) | External interrupt pins, asynchronous |
| irq_o | output | NUM_CH (32) | Per-channel masked interrupt outputs |

## Verification
A new edge detection and a software write-one-clear can land on the same detect bit in the same clock cycle. The bench provokes this by toggling a pin on a both-edges channel and timing the clear write so that it is accepted on the third rising edge after the toggle, which is the edge where the detection registers. The requirement is that the bit ends up set. A later isolated clear then confirms that clearing works when no detection competes with it. A second overlap comes from level channels, where a clear is issued while the level is still active: the bit must survive that clear, and it must drop only under a clear issued after the pin has gone inactive.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SENSE_W = 6;

  // sense code bit positions
  localparam int unsigned SNS_LOW  = 0;
  localparam int unsigned SNS_HIGH = 1;
  localparam int unsigned SNS_FALL = 2;
  localparam int unsigned SNS_RISE = 3;

  // fixed register locations (byte addresses)
  localparam int unsigned OFS_REQ    = 'h00;
  localparam int unsigned OFS_EN_CLR = 'h04;
  localparam int unsigned OFS_EN_SET = 'h08;
  localparam int unsigned CPU_STRIDE = 'h10;
  localparam int unsigned OFS_DET    = 'h100;
  localparam int unsigned OFS_MON    = 'h104;
  localparam int unsigned OFS_CFG    = 'h180;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] prev_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], pin_i[c]};
    end
    assign lvl_o[c] = sh[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '0;
    else        prev_o <= lvl_o;
  end
endmodule

// File: rtl/eis_chan.sv
module eis_chan
  import eis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_W-1:0] cfg,
  input  logic               lvl,
  input  logic               prev,
  input  logic               clr,
  output logic               detect
);
  logic evt;

  always_comb begin
    evt = (cfg[SNS_LOW]  & ~lvl)
        | (cfg[SNS_HIGH] &  lvl)
        | (cfg[SNS_FALL] &  prev & ~lvl)
        | (cfg[SNS_RISE] & ~prev &  lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) detect <= 1'b0;
    else        detect <= evt | (detect & ~clr);
  end

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[SNS_HIGH] && lvl) |=> detect);

  // R4
  rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[SNS_RISE] && lvl && !prev) |=> detect);

  // R5
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && cfg[3:0] == 4'b0) |=> !detect);

  // R9
  no_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0 && !detect) |=> !detect);
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CPU_SEL = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  input  logic [NUM_CH-1:0]               detect,
  input  logic [NUM_CH-1:0]               level,
  output logic [NUM_CH-1:0][SENSE_W-1:0]  cfg_o,
  output logic [NUM_CH-1:0]               en_o,
  output logic [NUM_CH-1:0]               clr_o,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_data
);
  localparam int unsigned BLK     = CPU_SEL * CPU_STRIDE;
  localparam int unsigned A_REQ   = BLK + OFS_REQ;
  localparam int unsigned A_CLR   = BLK + OFS_EN_CLR;
  localparam int unsigned A_SET   = BLK + OFS_EN_SET;
  localparam int unsigned CFG_END = OFS_CFG + 4 * NUM_CH;
  localparam int unsigned IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              wr, rd, aligned, cfg_hit, mapped;
  logic [31:0]       a32, cfg_off;
  logic [IDX_W-1:0]  cfg_idx;
  logic [DATA_W-1:0] rd_val;

  assign a32     = 32'(req_addr);
  assign wr      = req_valid &  req_write;
  assign rd      = req_valid & ~req_write;
  assign aligned = (req_addr[1:0] == 2'b00);
  assign cfg_off = a32 - OFS_CFG;
  assign cfg_idx = cfg_off[2 +: IDX_W];
  assign cfg_hit = aligned && (a32 >= OFS_CFG) && (a32 < CFG_END);
  assign mapped  = cfg_hit || a32 == A_REQ || a32 == A_CLR || a32 == A_SET
                || a32 == OFS_DET || a32 == OFS_MON;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else if (wr && cfg_hit) begin
      for (int c = 0; c < NUM_CH; c++)
        if (cfg_idx == IDX_W'(c)) cfg_o[c] <= req_wdata[SENSE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_o <= '0;
    else if (wr && a32 == A_SET) en_o <= en_o |  req_wdata[NUM_CH-1:0];
    else if (wr && a32 == A_CLR) en_o <= en_o & ~req_wdata[NUM_CH-1:0];
  end

  assign clr_o = (wr && a32 == OFS_DET) ? req_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rd_val = '0;
    if (cfg_hit) begin
      rd_val[SENSE_W-1:0] = cfg_o[cfg_idx];
    end else if (a32 == A_REQ) begin
      rd_val[NUM_CH-1:0] = detect & en_o;
    end else if (a32 == A_CLR) begin
      rd_val[NUM_CH-1:0] = en_o;
    end else if (a32 == OFS_DET) begin
      rd_val[NUM_CH-1:0] = detect;
    end else if (a32 == OFS_MON) begin
      rd_val[NUM_CH-1:0] = level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rd_val : '0;
    end
  end

  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && a32 == A_SET) |=> ((en_o & $past(req_wdata[NUM_CH-1:0])) == $past(req_wdata[NUM_CH-1:0])));

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(en_o) && $stable(cfg_o)));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CPU_SEL     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]              lvl, prev, det, en, clr;
  logic [NUM_CH-1:0][SENSE_W-1:0] cfg;

  assign req_ready = 1'b1;

  eis_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    eis_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[c]), .lvl(lvl[c]),
      .prev(prev[c]), .clr(clr[c]), .detect(det[c])
    );
  end

  eis_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CPU_SEL(CPU_SEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .detect(det), .level(lvl),
    .cfg_o(cfg), .en_o(en), .clr_o(clr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign irq_o = det & en;

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~en) == '0);
endmodule

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] pins = '0;
  logic [31:0] irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ext_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pin_i(pins), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual unexpected response %h expected none", rsp_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    check("R10 ready", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", irq, 32'h0);
    rd(12'h000, 32'h0, "R1 req");
    rd(12'h004, 32'h0, "R1 enable");
    rd(12'h100, 32'h0, "R1 detect");
    rd(12'h104, 32'h0, "R1 monitor");
    rd(12'h180, 32'h0, "R1 cfg0");
    // R9 unmapped and write-only
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h0, "R9 unmapped read");
    rd(12'h300, 32'h0, "R9 unmapped read hi");
    rd(12'h004, 32'h0, "R9 write ignored");
    // configure channels (R2)
    wr(12'h180, 32'h0000_0001);       // ch0 low
    wr(12'h184, 32'h0000_0002);       // ch1 high
    wr(12'h188, 32'h0000_0008);       // ch2 rise
    wr(12'h18C, 32'h0000_0004);       // ch3 fall
    wr(12'h190, 32'h0000_000C);       // ch4 both
    wr(12'h198, 32'h5A5A_5A44);       // ch6 fall, upper bits dropped
    wr(12'h19C, 32'hFFFF_FFC0);       // ch7 no sense
    rd(12'h198, 32'h0000_0004, "R2 cfg field");
    rd(12'h19C, 32'h0, "R2 cfg upper bits");
    rd(12'h184, 32'h0000_0002, "R2 cfg ch1");
    rd(12'h100, 32'h0000_0001, "R3 low level detect");
    // raise pins 1,2,4,5,7
    pins = 32'h0000_00B6;
    idle(4);
    rd(12'h104, 32'h0000_00B6, "R8 monitor");
    rd(12'h100, 32'h0000_0017, "R4 R3 detect mix, R9 none");
    // enables
    wr(12'h008, 32'hFFFF_FFFF);
    check("R7 irq all enabled", irq, 32'h0000_0017);
    rd(12'h004, 32'hFFFF_FFFF, "R6 enable mask");
    rd(12'h008, 32'h0, "R9 enable-set reads 0");
    wr(12'h004, 32'h0000_0004);
    rd(12'h004, 32'hFFFF_FFFB, "R6 enable clear");
    rd(12'h000, 32'h0000_0013, "R7 request status");
    check("R7 irq masked", irq, 32'h0000_0013);
    // write-one-clear
    wr(12'h100, 32'h0);
    rd(12'h100, 32'h0000_0017, "R5 write zero");
    wr(12'h100, 32'h0000_0017);
    rd(12'h100, 32'h0000_0003, "R3 clear while level active");
    pins = 32'h0000_00B5;
    idle(4);
    rd(12'h100, 32'h0000_0003, "R3 sticky after release");
    wr(12'h100, 32'h0000_0003);
    rd(12'h100, 32'h0, "R3 clear after release");
    // falling edges
    pins = 32'h0000_00BD;
    idle(4);
    rd(12'h100, 32'h0, "R4 fall ignores rise");
    pins = 32'h0000_00A1;
    idle(4);
    rd(12'h100, 32'h0000_0018, "R4 fall and both");
    check("R7 irq edges", irq, 32'h0000_0018);
    wr(12'h100, 32'h0000_0018);
    // latency on ch2 rise
    wr(12'h008, 32'h0000_0004);
    @(negedge clk);
    pins = 32'h0000_00A5;
    @(negedge clk);
    @(negedge clk);
    check("R4 not yet after 2 edges", irq, 32'h0);
    @(negedge clk);
    check("R4 visible after 3 edges", irq, 32'h0000_0004);
    wr(12'h100, 32'h0000_0004);
    // detection and clear in the same cycle on ch4
    @(negedge clk);
    pins = 32'h0000_00B5;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h100; req_wdata = 32'h0000_0010;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(12'h100, 32'h0000_0010, "R5 set wins over clear");
    wr(12'h100, 32'h0000_0010);
    rd(12'h100, 32'h0, "R5 clear alone");
    idle(2);
    check("R10 queue drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule